// File: doc/BRIEF.md
# Code Memory Lock and Scrambled Verify Unit

This block guards the on-chip program store. It keeps a graded set of three one-time lock fuses and a 64-entry byte table of scrambling keys. From the fuses it decodes a protection level and raises four permission flags. These flags control whether external table reads may reach internal code, whether code and keys may still be programmed, whether verify reads are served, and whether execution from external memory is allowed. When a fuse is set, the block also freezes the external-access strap at reset.

During a verify read the block takes the code byte fetched by the array and the key byte picked by the low six address bits. It returns the bitwise XNOR of the two. A separate mode returns fixed identification bytes. The programming controller drives a three-bit mode, an address, the code read data, per-fuse program strobes and a key write port. It then uses the flags to gate its own operations.

Top module: `code_guard`

## Requirements
- R1: After power-up every key byte is FFh, so a verify read (mode 1) returns the code byte unchanged.
- R2: In mode 1, with verify permitted, `vfy_data` equals the bitwise XNOR of `code_rdata` and the key byte indexed by `addr[5:0]`. It appears one clock after the inputs are presented.
- R3: In mode 1 a code byte of FFh returns the indexed key byte itself.
- R4: A key write takes effect only when `mode` is 3, `key_we` is 1 and `prog_ok` is 1. The stored byte becomes old AND `key_wdata`, so bits can only fall from 1 to 0. The new value is visible from the next clock.
- R5: In mode 5, at every lock level, `vfy_data` is 89h for address 0030h, 58h for 0031h, EBh for 0060h and 00h for any other address. The result appears one clock later.
- R6: `lock_strobe[i]` programs fuse i only in mode 4. A programmed fuse never returns to unprogrammed, and `rst_n` does not clear it.
- R7: With fuse pattern 000, all four flags are 1, and verify data is still scrambled per R2.
- R8: With fuse pattern 001 (fuse 0 only), `table_fetch_ok` and `prog_ok` are 0 while `vfy_ok` and `ext_exec_ok` stay 1. `ea_eff` then holds the value of `ext_access_pin` sampled on the last clock with `rst_n` low.
- R9: With fuse pattern 011, `vfy_ok` is also 0, and a mode 1 read returns 00h.
- R10: With fuse pattern 111, `ext_exec_ok` is also 0.
- R11: Any other fuse pattern clears all four flags.
- R12: With fuse pattern 000, `ea_eff` follows `ext_access_pin` with no delay.
- R13: In modes other than 1 and 5, `vfy_data` is 00h one clock later. During `rst_n` low it is also 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the volatile state |
| mode | input | 3 | 0 run, 1 verify, 2 program code, 3 program key, 4 program fuse, 5 identification |
| addr | input | 13 | Code address for verify and identification reads |
| code_rdata | input | 8 | Byte read from the code array at `addr` |
| lock_strobe | input | 3 | One program strobe per fuse |
| key_we | input | 1 | Key table write request |
| key_addr | input | 6 | Key table write index |
| key_wdata | input | 8 | Key table write data (bits at 0 are programmed) |
| ext_access_pin | input | 1 | External-access strap |
| vfy_data | output | 8 | Verify or identification read data |
| table_fetch_ok | output | 1 | External table reads may fetch internal code |
| prog_ok | output | 1 | Code and key programming allowed |
| vfy_ok | output | 1 | Verify reads allowed |
| ext_exec_ok | output | 1 | Execution from external memory allowed |
| ea_eff | output | 1 | Effective external-access strap |

## Verification
Read data is registered once, so a verify or identification result is due on the clock after its inputs. Flags and `ea_eff` are combinational from the fuse state, so they change on the same edge that programs a fuse. `ea_eff` also tracks the strap directly while unlocked. The bench drives every stimulus on a falling edge and samples on the next falling edge. This is exactly one rising edge later, which covers both the one-cycle read results and the same-edge flag changes. Key writes are sampled through a verify read issued one cycle after the write edge.

// File: rtl/cg_pkg.sv
package cg_pkg;

    typedef enum logic [2:0] {
        MD_RUN       = 3'd0,
        MD_VERIFY    = 3'd1,
        MD_PROG_CODE = 3'd2,
        MD_PROG_KEY  = 3'd3,
        MD_LOCK      = 3'd4,
        MD_IDENT     = 3'd5
    } mode_e;

    // Identification bytes, looked up by full read address
    function automatic logic [7:0] ident_byte(input logic [15:0] a);
        logic [7:0] r;
        case (a)
            16'h0030: r = 8'h89;
            16'h0031: r = 8'h58;
            16'h0060: r = 8'hEB;
            default:  r = 8'h00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cg_lock_ctl.sv
module cg_lock_ctl
    import cg_pkg::*;
#(
    parameter int NUM_LOCK = 3
) (
    input  logic                clk,
    input  mode_e               mode,
    input  logic [NUM_LOCK-1:0] lock_strobe,
    output logic [NUM_LOCK-1:0] lock_bits,
    output logic                table_fetch_ok,
    output logic                prog_ok,
    output logic                vfy_ok,
    output logic                ext_exec_ok
);
    localparam int LVL_W = $clog2(NUM_LOCK + 1);
    localparam logic [LVL_W-1:0] LVL_OPEN    = LVL_W'(0);
    localparam logic [LVL_W-1:0] LVL_NO_VFY  = LVL_W'(2);
    localparam logic [LVL_W-1:0] LVL_NO_EXEC = LVL_W'(3);
    localparam logic [LVL_W-1:0] LVL_MAX     = LVL_W'(NUM_LOCK);

    typedef struct packed {
        logic [NUM_LOCK-1:0] fuse;
    } lock_st_t;

    // Fuses are non-volatile: power-up value only, no reset term
    lock_st_t st_q = '0;
    lock_st_t st_d;
    logic [LVL_W-1:0] level;

    always_comb begin
        st_d = st_q;
        if (mode == MD_LOCK) begin
            st_d.fuse = st_q.fuse | lock_strobe;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // Thermometer patterns map to their level; anything else is the top level
    always_comb begin
        level = LVL_MAX;
        for (int k = 0; k <= NUM_LOCK; k++) begin
            if (st_q.fuse == NUM_LOCK'((1 << k) - 1)) begin
                level = LVL_W'(k);
            end
        end
    end

    assign lock_bits      = st_q.fuse;
    assign table_fetch_ok = (level == LVL_OPEN);
    assign prog_ok        = (level == LVL_OPEN);
    assign vfy_ok         = (level <  LVL_NO_VFY);
    assign ext_exec_ok    = (level <  LVL_NO_EXEC);

endmodule

// File: rtl/cg_key_store.sv
module cg_key_store #(
    parameter int KEY_DEPTH = 64,
    parameter int DATA_W    = 8,
    localparam int KEY_AW   = $clog2(KEY_DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [KEY_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [KEY_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] cells [KEY_DEPTH];

    for (genvar i = 0; i < KEY_DEPTH; i++) begin : g_cell
        // Erased state is all ones; programming can only clear bits
        logic [DATA_W-1:0] cell_q = '1;
        logic [DATA_W-1:0] cell_d;

        always_comb begin
            cell_d = cell_q;
            if (wr_en && (wr_addr == KEY_AW'(i))) begin
                cell_d = cell_q & wr_data;
            end
        end

        always_ff @(posedge clk) begin
            cell_q <= cell_d;
        end

        assign cells[i] = cell_q;
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/cg_vfy_path.sv
module cg_vfy_path
    import cg_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] code_rdata,
    input  logic [DATA_W-1:0] key_byte,
    input  logic              vfy_ok,
    output logic [DATA_W-1:0] vfy_data
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
    } vfy_st_t;

    vfy_st_t st_q = '0;
    vfy_st_t st_d;

    always_comb begin
        st_d = '0;
        case (mode)
            MD_VERIFY: begin
                if (vfy_ok) begin
                    st_d.data = ~(code_rdata ^ key_byte);
                end
            end
            MD_IDENT: st_d.data = DATA_W'(ident_byte(16'(addr)));
            default:  st_d.data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vfy_data = st_q.data;

endmodule

// File: rtl/code_guard.sv
module code_guard
    import cg_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int KEY_DEPTH = 64,
    parameter int NUM_LOCK  = 3,
    localparam int KEY_AW   = $clog2(KEY_DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          mode,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   code_rdata,
    input  logic [NUM_LOCK-1:0] lock_strobe,
    input  logic                key_we,
    input  logic [KEY_AW-1:0]   key_addr,
    input  logic [DATA_W-1:0]   key_wdata,
    input  logic                ext_access_pin,
    output logic [DATA_W-1:0]   vfy_data,
    output logic                table_fetch_ok,
    output logic                prog_ok,
    output logic                vfy_ok,
    output logic                ext_exec_ok,
    output logic                ea_eff
);
    typedef struct packed {
        logic ea_lat;
    } top_st_t;

    mode_e               mode_c;
    logic [NUM_LOCK-1:0] lock_bits;
    logic [DATA_W-1:0]   key_byte;
    logic                key_wr_en;
    top_st_t             st_q = '0;
    top_st_t             st_d;

    assign mode_c = mode_e'(mode);

    cg_lock_ctl #(
        .NUM_LOCK (NUM_LOCK)
    ) u_lock (
        .clk            (clk),
        .mode           (mode_c),
        .lock_strobe    (lock_strobe),
        .lock_bits      (lock_bits),
        .table_fetch_ok (table_fetch_ok),
        .prog_ok        (prog_ok),
        .vfy_ok         (vfy_ok),
        .ext_exec_ok    (ext_exec_ok)
    );

    assign key_wr_en = key_we && prog_ok && (mode_c == MD_PROG_KEY);

    cg_key_store #(
        .KEY_DEPTH (KEY_DEPTH),
        .DATA_W    (DATA_W)
    ) u_keys (
        .clk     (clk),
        .wr_en   (key_wr_en),
        .wr_addr (key_addr),
        .wr_data (key_wdata),
        .rd_addr (addr[KEY_AW-1:0]),
        .rd_data (key_byte)
    );

    cg_vfy_path #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_vfy (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_c),
        .addr       (addr),
        .code_rdata (code_rdata),
        .key_byte   (key_byte),
        .vfy_ok     (vfy_ok),
        .vfy_data   (vfy_data)
    );

    // Strap capture: tracks the pin while reset is held, frozen afterwards
    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.ea_lat = ext_access_pin;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ea_eff = (lock_bits == '0) ? ext_access_pin : st_q.ea_lat;

endmodule

// File: rtl/cg_chk.sv
module cg_chk #(
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 8,
    parameter int NUM_LOCK = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          mode,
    input logic [ADDR_W-1:0]   addr,
    input logic [NUM_LOCK-1:0] lock_bits,
    input logic                prog_ok,
    input logic                vfy_ok,
    input logic                ext_exec_ok,
    input logic [DATA_W-1:0]   vfy_data
);
    AST_FUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lock_bits & $past(lock_bits)) == $past(lock_bits))); // R6

    AST_PROG_IMPLIES_VFY: assert property (@(posedge clk) disable iff (!rst_n)
        prog_ok |-> (vfy_ok && ext_exec_ok)); // R8

    AST_VFY_IMPLIES_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        vfy_ok |-> ext_exec_ok); // R10

    AST_VFY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 3'd1) && !vfy_ok) |=> (vfy_data == '0)); // R9

    AST_IDENT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 3'd5) && (addr == ADDR_W'(16'h0030))) |=> (vfy_data == DATA_W'(8'h89))); // R5

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 3'd0) || (mode == 3'd4)) |=> (vfy_data == '0)); // R13

endmodule

bind code_guard cg_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_LOCK (NUM_LOCK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .addr        (addr),
    .lock_bits   (lock_bits),
    .prog_ok     (prog_ok),
    .vfy_ok      (vfy_ok),
    .ext_exec_ok (ext_exec_ok),
    .vfy_data    (vfy_data)
);

// File: tb/code_guard_tb_top.sv
`timescale 1ns/1ps
module code_guard_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [12:0] addr = '0;
    logic [7:0]  code_rdata = '0;
    logic [2:0]  lock_strobe = '0;
    logic [2:0]  ls_u = '0;
    logic        key_we = 1'b0;
    logic [5:0]  key_addr = '0;
    logic [7:0]  key_wdata = '0;
    logic        ext_pin = 1'b1;

    logic [7:0]  vfy_data, vfy_u;
    logic        tf_ok, pg_ok, vf_ok, ex_ok, ea_eff;
    logic        tf_u, pg_u, vf_u, ex_u, ea_u;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_key [64];

    always #4 clk = ~clk;

    code_guard dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .code_rdata(code_rdata),
        .lock_strobe(lock_strobe), .key_we(key_we), .key_addr(key_addr),
        .key_wdata(key_wdata), .ext_access_pin(ext_pin), .vfy_data(vfy_data),
        .table_fetch_ok(tf_ok), .prog_ok(pg_ok), .vfy_ok(vf_ok),
        .ext_exec_ok(ex_ok), .ea_eff(ea_eff)
    );

    // Second copy used only for a non-thermometer fuse pattern
    code_guard dut_u (
        .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .code_rdata(code_rdata),
        .lock_strobe(ls_u), .key_we(1'b0), .key_addr(key_addr),
        .key_wdata(key_wdata), .ext_access_pin(ext_pin), .vfy_data(vfy_u),
        .table_fetch_ok(tf_u), .prog_ok(pg_u), .vfy_ok(vf_u),
        .ext_exec_ok(ex_u), .ea_eff(ea_u)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic flags(input string req, input logic [3:0] exp);
        chk(req, {tf_ok, pg_ok, vf_ok, ex_ok}, 32'(exp));
    endtask

    task automatic verify_at(input string req, input logic [12:0] a, input logic [7:0] c,
                             input logic [7:0] exp);
        mode = 3'd1; addr = a; code_rdata = c;
        cyc();
        chk(req, vfy_data, exp);
        mode = 3'd0;
    endtask

    task automatic key_write(input logic [5:0] a, input logic [7:0] d, input logic [2:0] m);
        mode = m; key_we = 1'b1; key_addr = a; key_wdata = d;
        cyc();
        key_we = 1'b0; mode = 3'd0;
    endtask

    task automatic fuse(input logic [2:0] s, input logic [2:0] m);
        mode = m; lock_strobe = s;
        cyc();
        lock_strobe = '0; mode = 3'd0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) exp_key[i] = 8'hFF;
        repeat (4) cyc();
        chk("R13 reset", vfy_data, 8'h00);
        rst_n = 1'b1;
        cyc();
        flags("R7 open", 4'b1111);
        ext_pin = 1'b0; #1;
        chk("R12 pin low", ea_eff, 1'b0);
        ext_pin = 1'b1; #1;
        chk("R12 pin high", ea_eff, 1'b1);

        // Undefined fuse pattern on the second copy
        mode = 3'd4; ls_u = 3'b010;
        cyc();
        ls_u = '0; mode = 3'd0;
        chk("R11 undefined", {tf_u, pg_u, vf_u, ex_u}, 32'h0);

        // Untouched keys: transparent
        for (int c = 0; c < 256; c++) begin
            verify_at("R1 erased", 13'(c * 29), 8'(c), 8'(c));
        end

        mode = 3'd0; code_rdata = 8'h5A;
        cyc();
        chk("R13 run mode", vfy_data, 8'h00);
        mode = 3'd2;
        cyc();
        chk("R13 prog mode", vfy_data, 8'h00);
        mode = 3'd0;

        for (int i = 0; i < 64; i++) begin
            logic [7:0] v;
            v = 8'((i * 37 + 11) ^ (i << 2));
            key_write(6'(i), v, 3'd3);
            exp_key[i] = exp_key[i] & v;
        end

        for (int a = 0; a < 512; a++) begin
            logic [7:0] c;
            c = 8'((a * 13) ^ 8'h5A);
            verify_at("R2 scramble", 13'(a * 5), c, ~(c ^ exp_key[(a * 5) % 64]));
        end

        for (int i = 0; i < 64; i++) begin
            verify_at("R3 ones", 13'(i + 128), 8'hFF, exp_key[i]);
        end

        key_write(6'd5, 8'h0F, 3'd3);
        exp_key[5] = exp_key[5] & 8'h0F;
        verify_at("R4 and-only", 13'd5, 8'hFF, exp_key[5]);
        key_write(6'd6, 8'h00, 3'd0);
        verify_at("R4 wrong mode", 13'd6, 8'hFF, exp_key[6]);
        key_write(6'd7, 8'h00, 3'd1);
        verify_at("R4 verify mode", 13'd7, 8'hFF, exp_key[7]);

        mode = 3'd5;
        addr = 13'h0030; cyc(); chk("R5 id 30", vfy_data, 8'h89);
        addr = 13'h0031; cyc(); chk("R5 id 31", vfy_data, 8'h58);
        addr = 13'h0060; cyc(); chk("R5 id 60", vfy_data, 8'hEB);
        addr = 13'h0032; cyc(); chk("R5 other", vfy_data, 8'h00);
        addr = 13'h1030; cyc(); chk("R5 upper", vfy_data, 8'h00);
        mode = 3'd0;

        fuse(3'b001, 3'd0);
        flags("R6 strobe outside mode", 4'b1111);

        fuse(3'b001, 3'd4);
        flags("R8 level one", 4'b0011);
        key_write(6'd9, 8'h00, 3'd3);
        verify_at("R8 key frozen", 13'd9, 8'hFF, exp_key[9]);

        ext_pin = 1'b1; rst_n = 1'b0;
        cyc(); cyc();
        rst_n = 1'b1; ext_pin = 1'b0; #1;
        chk("R8 strap latched", ea_eff, 1'b1);
        flags("R6 kept over reset", 4'b0011);
        ext_pin = 1'b0; rst_n = 1'b0;
        cyc();
        rst_n = 1'b1; ext_pin = 1'b1; #1;
        chk("R8 strap latched low", ea_eff, 1'b0);

        fuse(3'b010, 3'd4);
        flags("R9 level two", 4'b0001);
        verify_at("R9 verify off", 13'd3, 8'h3C, 8'h00);
        mode = 3'd5; addr = 13'h0031;
        cyc();
        chk("R5 id when locked", vfy_data, 8'h58);
        mode = 3'd0;

        fuse(3'b100, 3'd4);
        flags("R10 level three", 4'b0000);
        fuse(3'b000, 3'd4);
        flags("R6 no clear", 4'b0000);

        finish_run();
    end
endmodule